// File: doc/BRIEF.md
# Control Endpoint Stage Sequencer

This block follows a device controller's endpoint 0 through each control transfer. A packet layer sends it single-cycle event pulses: a SETUP packet together with its request type and length fields, acknowledged IN data packets, received OUT data packets, completed zero-length status handshakes, and status tokens that were NAKed. Firmware sends it single-cycle control pulses that acknowledge the setup, mark the transmit buffer as loaded, and end the data stage. It also drives a write-1-to-clear vector and a mask vector for the interrupt flags.

From these inputs the block keeps the current stage, a transmit-buffer-loaded flag, a setup-pending flag, a sticky stage-error flag and four pending interrupt flags. It also reports whether the latched request is a class or vendor request that firmware must answer. It counts the bytes the data stage still owes against the request length, so that a host which moves to the status stage early can be detected. After firmware ends the data stage, the status stage finishes with no further firmware action.

Top module: `ep0_ctl_seq`

## Requirements
- R1: After a synchronous reset the stage is IDLE and buf_loaded, setup_pend, stage_err, req_fw, irq_pend and irq are all 0. The stage codes are IDLE=0, SETUP=1, DATA_IN=2, DATA_OUT=3, STATUS_IN=4 and STATUS_OUT=5.
- R2: A pk_setup pulse in any stage moves the stage to SETUP on the next cycle. It clears buf_loaded, sets setup_pend and sets irq_pend[0] (setup), and this event takes priority over every other input in that cycle.
- R3: req_fw is 1 after a setup whose request-type byte has bits [6:5] equal to 01 (class) or 10 (vendor), for example 8'b110000xx. Otherwise req_fw is 0.
- R4: In SETUP, fw_setup_ack clears setup_pend and stage_err. It moves the stage to STATUS_IN when the length is 0, to DATA_IN when request-type bit 7 is 1, and to DATA_OUT otherwise. In other stages it is ignored.
- R5: In DATA_IN, fw_buf_loaded sets buf_loaded. A pk_in_ack while buf_loaded is 1 clears it, sets irq_pend[1] (endpoint) and counts pk_len bytes. If fw_buf_loaded arrives in the same cycle, buf_loaded stays 1. A pk_in_ack while buf_loaded is 0 is ignored.
- R6: In DATA_OUT, pk_out_data sets irq_pend[1] and counts pk_len bytes. A length above the maximum payload of 8 counts as 8.
- R7: fw_eop moves DATA_IN to STATUS_OUT and DATA_OUT to STATUS_IN. In every other stage it is ignored.
- R8: In STATUS_IN or STATUS_OUT, pk_status_zlp moves the stage to IDLE and sets irq_pend[2] (status done). In other stages it is ignored.
- R9: A pk_setup while the stage is STATUS_IN or STATUS_OUT sets stage_err. The flag then stays set until fw_setup_ack is accepted, and a setup in any other stage leaves it unchanged.
- R10: In DATA_IN or DATA_OUT, pk_status_nak sets irq_pend[3] (early status) only while fewer bytes than the request length have been counted.
- R11: A 1 in fw_irq_clr clears that bit of irq_pend. An event that sets the same bit in that cycle wins over the clear.
- R12: irq is 1 exactly when some bit of irq_pend is 1 and the matching fw_irq_mask bit is 0, and it follows a mask change in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pk_setup | input | 1 | SETUP packet received (pulse) |
| su_bmreq | input | 8 | Request-type byte of that setup |
| su_wlen | input | WLEN_W | Length field of that setup |
| pk_in_ack | input | 1 | IN data packet acknowledged by host |
| pk_out_data | input | 1 | OUT data packet received |
| pk_len | input | LEN_W | Byte count of the data packet |
| pk_status_zlp | input | 1 | Status zero-length handshake completed |
| pk_status_nak | input | 1 | Status token NAKed during data stage |
| fw_setup_ack | input | 1 | Firmware has seen the setup |
| fw_buf_loaded | input | 1 | Firmware loaded a transmit packet |
| fw_eop | input | 1 | Firmware ends the data stage |
| fw_irq_clr | input | 4 | Write-1-to-clear for irq_pend |
| fw_irq_mask | input | 4 | Interrupt masks, 1 masks |
| stage | output | 3 | Current stage code |
| buf_loaded | output | 1 | Transmit buffer holds a packet |
| setup_pend | output | 1 | Setup not yet acknowledged |
| stage_err | output | 1 | Previous status stage was cut short |
| req_fw | output | 1 | Class or vendor request for firmware |
| irq_pend | output | 4 | Pending flags: setup, endpoint, status done, early status |
| irq | output | 1 | OR of unmasked pending flags |

## Verification
The hardest cases to reach are the interactions between events: a setup that arrives during a status stage, a NAKed status token while bytes are still owed, and set and clear landing on the same flag in one cycle. Reaching them requires a setup, an acknowledgment, buffer loads and end-of-data to arrive in the right order. A directed prefix steps a control read and a control write through these cases by hand. After that, weighted random pulses on every input run against a cycle model in the bench, so that collisions such as ack with setup, or load with IN acknowledgment, happen many times.

// File: rtl/ep0_seq_pkg.sv
package ep0_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_DIN   = 3'd2,
        ST_DOUT  = 3'd3,
        ST_SIN   = 3'd4,
        ST_SOUT  = 3'd5
    } ep0_stage_e;

    localparam int IRQ_N      = 4;
    localparam int IRQ_SETUP  = 0;
    localparam int IRQ_EP0    = 1;
    localparam int IRQ_STDONE = 2;
    localparam int IRQ_STNAK  = 3;

    // class (01) or vendor (10) request type needs firmware
    function automatic logic needs_fw(input logic [7:0] bmreq);
        return (bmreq[6:5] == 2'b01) || (bmreq[6:5] == 2'b10);
    endfunction

    function automatic logic is_status(input ep0_stage_e s);
        return (s == ST_SIN) || (s == ST_SOUT);
    endfunction

    function automatic logic is_data(input ep0_stage_e s);
        return (s == ST_DIN) || (s == ST_DOUT);
    endfunction

endpackage

// File: rtl/ep0_req_track.sv
module ep0_req_track #(
    parameter int WLEN_W  = 16,
    parameter int LEN_W   = 4,
    parameter int MAX_PKT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pk_setup,
    input  logic [7:0]        su_bmreq,
    input  logic [WLEN_W-1:0] su_wlen,
    input  logic              take,
    input  logic [LEN_W-1:0]  take_len,
    output logic              dir_in,
    output logic              wlen_zero,
    output logic              all_sent,
    output logic              fw_req
);
    localparam logic [LEN_W-1:0] CAP = LEN_W'(MAX_PKT);

    logic [WLEN_W-1:0] remain;
    logic [LEN_W-1:0]  eff_len;
    logic [WLEN_W-1:0] eff_wide;

    always_comb begin
        eff_len  = (take_len > CAP) ? CAP : take_len;
        eff_wide = WLEN_W'(eff_len);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            remain    <= '0;
            dir_in    <= 1'b0;
            wlen_zero <= 1'b1;
            fw_req    <= 1'b0;
        end else if (pk_setup) begin
            remain    <= su_wlen;
            dir_in    <= su_bmreq[7];
            wlen_zero <= (su_wlen == '0);
            fw_req    <= ep0_seq_pkg::needs_fw(su_bmreq);
        end else if (take) begin
            remain <= (remain > eff_wide) ? (remain - eff_wide) : '0;
        end
    end

    assign all_sent = (remain == '0);
endmodule

// File: rtl/ep0_stage_fsm.sv
module ep0_stage_fsm
    import ep0_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pk_setup,
    input  logic             pk_in_ack,
    input  logic             pk_out_data,
    input  logic             pk_status_zlp,
    input  logic             pk_status_nak,
    input  logic             fw_setup_ack,
    input  logic             fw_buf_loaded,
    input  logic             fw_eop,
    input  logic             dir_in,
    input  logic             wlen_zero,
    input  logic             all_sent,
    output ep0_stage_e       stage,
    output logic             buf_loaded,
    output logic             setup_pend,
    output logic             stage_err,
    output logic             take,
    output logic [IRQ_N-1:0] ev
);
    ep0_stage_e st_n;
    logic       buf_n, sp_n, err_n;

    always_comb begin
        st_n  = stage;
        buf_n = buf_loaded;
        sp_n  = setup_pend;
        err_n = stage_err;
        ev    = '0;
        take  = 1'b0;
        if (pk_setup) begin
            st_n          = ST_SETUP;
            buf_n         = 1'b0;
            sp_n          = 1'b1;
            ev[IRQ_SETUP] = 1'b1;
            if (is_status(stage)) err_n = 1'b1;
        end else begin
            if (is_data(stage) && pk_status_nak && !all_sent)
                ev[IRQ_STNAK] = 1'b1;
            unique case (stage)
                ST_SETUP: if (fw_setup_ack) begin
                    sp_n  = 1'b0;
                    err_n = 1'b0;
                    st_n  = wlen_zero ? ST_SIN : (dir_in ? ST_DIN : ST_DOUT);
                end
                ST_DIN: begin
                    if (pk_in_ack && buf_loaded) begin
                        take        = 1'b1;
                        buf_n       = 1'b0;
                        ev[IRQ_EP0] = 1'b1;
                    end
                    if (fw_buf_loaded) buf_n = 1'b1;
                    if (fw_eop)        st_n  = ST_SOUT;
                end
                ST_DOUT: begin
                    if (pk_out_data) begin
                        take        = 1'b1;
                        ev[IRQ_EP0] = 1'b1;
                    end
                    if (fw_eop) st_n = ST_SIN;
                end
                ST_SIN, ST_SOUT: if (pk_status_zlp) begin
                    st_n           = ST_IDLE;
                    ev[IRQ_STDONE] = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage      <= ST_IDLE;
            buf_loaded <= 1'b0;
            setup_pend <= 1'b0;
            stage_err  <= 1'b0;
        end else begin
            stage      <= st_n;
            buf_loaded <= buf_n;
            setup_pend <= sp_n;
            stage_err  <= err_n;
        end
    end
endmodule

// File: rtl/ep0_irq_bank.sv
module ep0_irq_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_ev,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] mask,
    output logic [N-1:0] pend,
    output logic         irq
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)            pend[i] <= 1'b0;
            else if (set_ev[i]) pend[i] <= 1'b1;
            else if (clr[i])    pend[i] <= 1'b0;
        end
    end

    assign irq = |(pend & ~mask);
endmodule

// File: rtl/ep0_ctl_seq.sv
module ep0_ctl_seq #(
    parameter int WLEN_W  = 16,
    parameter int MAX_PKT = 8,
    parameter int LEN_W   = $clog2(MAX_PKT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pk_setup,
    input  logic [7:0]        su_bmreq,
    input  logic [WLEN_W-1:0] su_wlen,
    input  logic              pk_in_ack,
    input  logic              pk_out_data,
    input  logic [LEN_W-1:0]  pk_len,
    input  logic              pk_status_zlp,
    input  logic              pk_status_nak,
    input  logic              fw_setup_ack,
    input  logic              fw_buf_loaded,
    input  logic              fw_eop,
    input  logic [3:0]        fw_irq_clr,
    input  logic [3:0]        fw_irq_mask,
    output logic [2:0]        stage,
    output logic              buf_loaded,
    output logic              setup_pend,
    output logic              stage_err,
    output logic              req_fw,
    output logic [3:0]        irq_pend,
    output logic              irq
);
    import ep0_seq_pkg::*;

    ep0_stage_e       stage_q;
    logic             dir_in, wlen_zero, all_sent, take;
    logic [IRQ_N-1:0] ev;

    ep0_req_track #(.WLEN_W(WLEN_W), .LEN_W(LEN_W), .MAX_PKT(MAX_PKT)) u_req (
        .clk(clk), .rst(rst), .pk_setup(pk_setup), .su_bmreq(su_bmreq),
        .su_wlen(su_wlen), .take(take), .take_len(pk_len),
        .dir_in(dir_in), .wlen_zero(wlen_zero), .all_sent(all_sent),
        .fw_req(req_fw)
    );

    ep0_stage_fsm u_fsm (
        .clk(clk), .rst(rst), .pk_setup(pk_setup), .pk_in_ack(pk_in_ack),
        .pk_out_data(pk_out_data), .pk_status_zlp(pk_status_zlp),
        .pk_status_nak(pk_status_nak), .fw_setup_ack(fw_setup_ack),
        .fw_buf_loaded(fw_buf_loaded), .fw_eop(fw_eop), .dir_in(dir_in),
        .wlen_zero(wlen_zero), .all_sent(all_sent), .stage(stage_q),
        .buf_loaded(buf_loaded), .setup_pend(setup_pend),
        .stage_err(stage_err), .take(take), .ev(ev)
    );

    ep0_irq_bank #(.N(IRQ_N)) u_irq (
        .clk(clk), .rst(rst), .set_ev(ev), .clr(fw_irq_clr),
        .mask(fw_irq_mask), .pend(irq_pend), .irq(irq)
    );

    assign stage = stage_q;
endmodule

// File: rtl/ep0_ctl_seq_chk.sv
module ep0_ctl_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       pk_setup,
    input logic       pk_in_ack,
    input logic       pk_status_zlp,
    input logic       fw_setup_ack,
    input logic       fw_buf_loaded,
    input logic       fw_eop,
    input logic [2:0] stage,
    input logic       buf_loaded,
    input logic       stage_err,
    input logic [3:0] irq_pend
);
    a_r1_stage_code: assert property (@(posedge clk) disable iff (rst)
        stage <= 3'd5);

    a_r2_setup_restarts: assert property (@(posedge clk) disable iff (rst)
        pk_setup |=> (stage == 3'd1 && !buf_loaded && irq_pend[0]));

    a_r4_ack_leaves_setup: assert property (@(posedge clk) disable iff (rst)
        (stage == 3'd1 && fw_setup_ack && !pk_setup)
        |=> (stage == 3'd2 || stage == 3'd3 || stage == 3'd4));

    a_r5_in_ack_frees: assert property (@(posedge clk) disable iff (rst)
        (stage == 3'd2 && buf_loaded && pk_in_ack && !fw_buf_loaded && !pk_setup)
        |=> (!buf_loaded && irq_pend[1]));

    a_r7_eop_to_status: assert property (@(posedge clk) disable iff (rst)
        (stage == 3'd2 && fw_eop && !pk_setup) |=> (stage == 3'd5));

    a_r8_status_done: assert property (@(posedge clk) disable iff (rst)
        ((stage == 3'd4 || stage == 3'd5) && pk_status_zlp && !pk_setup)
        |=> (stage == 3'd0 && irq_pend[2]));

    a_r9_late_setup_err: assert property (@(posedge clk) disable iff (rst)
        (pk_setup && (stage == 3'd4 || stage == 3'd5)) |=> stage_err);
endmodule

bind ep0_ctl_seq ep0_ctl_seq_chk u_chk (
    .clk(clk), .rst(rst), .pk_setup(pk_setup), .pk_in_ack(pk_in_ack),
    .pk_status_zlp(pk_status_zlp), .fw_setup_ack(fw_setup_ack),
    .fw_buf_loaded(fw_buf_loaded), .fw_eop(fw_eop), .stage(stage),
    .buf_loaded(buf_loaded), .stage_err(stage_err), .irq_pend(irq_pend)
);

// File: tb/sim_ep0_ctl_seq.sv
module sim_ep0_ctl_seq;
    localparam int CLK_NS = 10;
    localparam int WLEN_W = 16;
    localparam int LEN_W  = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic pk_setup = 0, pk_in_ack = 0, pk_out_data = 0, pk_status_zlp = 0;
    logic pk_status_nak = 0, fw_setup_ack = 0, fw_buf_loaded = 0, fw_eop = 0;
    logic [7:0] su_bmreq = '0;
    logic [WLEN_W-1:0] su_wlen = '0;
    logic [LEN_W-1:0] pk_len = '0;
    logic [3:0] fw_irq_clr = '0, fw_irq_mask = '0;
    logic [2:0] stage;
    logic buf_loaded, setup_pend, stage_err, req_fw, irq;
    logic [3:0] irq_pend;

    always #(CLK_NS/2) clk = ~clk;

    ep0_ctl_seq u0 (.*);

    int checks = 0, errors = 0;

    // bench reference state
    int m_stage, m_rem;
    bit m_buf, m_sp, m_err, m_req, m_dir, m_zero;
    logic [3:0] m_pend;

    function automatic bit exp_fw(input logic [7:0] b);
        int t = int'(b[6:5]);
        return t == 1 || t == 2;
    endfunction

    task automatic chkv(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        logic [3:0] ev = '0;
        int len = (int'(pk_len) > 8) ? 8 : int'(pk_len);
        if (rst) begin
            m_stage = 0; m_rem = 0; m_buf = 0; m_sp = 0; m_err = 0;
            m_req = 0; m_dir = 0; m_zero = 1; m_pend = '0;
            return;
        end
        if (pk_setup) begin
            if (m_stage == 4 || m_stage == 5) m_err = 1;
            m_stage = 1; m_buf = 0; m_sp = 1; ev[0] = 1;
            m_rem = int'(su_wlen); m_zero = (su_wlen == 0);
            m_dir = su_bmreq[7]; m_req = exp_fw(su_bmreq);
        end else begin
            case (m_stage)
                1: if (fw_setup_ack) begin
                    m_sp = 0; m_err = 0;
                    m_stage = m_zero ? 4 : (m_dir ? 2 : 3);
                end
                2: begin
                    if (pk_status_nak && m_rem != 0) ev[3] = 1;
                    if (pk_in_ack && m_buf) begin
                        m_buf = 0; ev[1] = 1;
                        m_rem = (m_rem > len) ? m_rem - len : 0;
                    end
                    if (fw_buf_loaded) m_buf = 1;
                    if (fw_eop) m_stage = 5;
                end
                3: begin
                    if (pk_status_nak && m_rem != 0) ev[3] = 1;
                    if (pk_out_data) begin
                        ev[1] = 1;
                        m_rem = (m_rem > len) ? m_rem - len : 0;
                    end
                    if (fw_eop) m_stage = 4;
                end
                4, 5: if (pk_status_zlp) begin m_stage = 0; ev[2] = 1; end
                default: ;
            endcase
        end
        m_pend = (m_pend & ~fw_irq_clr) | ev;
    endtask

    task automatic compare_model();
        chkv("R2 R4 R7 R8 stage", int'(stage), m_stage);
        chkv("R5 buf_loaded", int'(buf_loaded), int'(m_buf));
        chkv("R4 setup_pend", int'(setup_pend), int'(m_sp));
        chkv("R9 stage_err", int'(stage_err), int'(m_err));
        chkv("R3 req_fw", int'(req_fw), int'(m_req));
        chkv("R6 R10 R11 irq_pend", int'(irq_pend), int'(m_pend));
        chkv("R12 irq", int'(irq), int'(|(m_pend & ~fw_irq_mask)));
    endtask

    task automatic step();
        @(posedge clk);
        tick();
        #1;
        compare_model();
        @(negedge clk);
        pk_setup = 0; pk_in_ack = 0; pk_out_data = 0; pk_status_zlp = 0;
        pk_status_nak = 0; fw_setup_ack = 0; fw_buf_loaded = 0; fw_eop = 0;
        fw_irq_clr = '0;
    endtask

    task automatic do_setup(input logic [7:0] b, input int wl);
        pk_setup = 1; su_bmreq = b; su_wlen = WLEN_W'(wl);
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7331));
        @(negedge clk);
        rst = 1; step(); step(); rst = 0;
        // R1 reset state
        chkv("R1 stage", int'(stage), 0);
        chkv("R1 buf", int'(buf_loaded), 0);
        chkv("R1 pend", int'(irq_pend), 0);
        chkv("R1 irq", int'(irq), 0);
        chkv("R1 err", int'(stage_err), 0);
        chkv("R1 req_fw", int'(req_fw), 0);
        chkv("R1 setup_pend", int'(setup_pend), 0);

        // control read, vendor type, 20 bytes
        do_setup(8'hC0, 20);
        chkv("R2 stage", int'(stage), 1);
        chkv("R2 pend", int'(irq_pend), 4'b0001);
        chkv("R2 setup_pend", int'(setup_pend), 1);
        chkv("R3 vendor read", int'(req_fw), 1);
        fw_setup_ack = 1; step();
        chkv("R4 to DATA_IN", int'(stage), 2);
        chkv("R4 setup_pend", int'(setup_pend), 0);
        fw_buf_loaded = 1; step();
        chkv("R5 loaded", int'(buf_loaded), 1);
        pk_in_ack = 1; pk_len = 4'd8; step();
        chkv("R5 freed", int'(buf_loaded), 0);
        chkv("R5 ep0 flag", int'(irq_pend), 4'b0011);
        pk_in_ack = 1; fw_irq_clr = 4'b0010; step();
        chkv("R5 ack ignored when empty", int'(irq_pend), 4'b0001);
        pk_status_nak = 1; step();
        chkv("R10 early status", int'(irq_pend), 4'b1001);
        fw_irq_mask = 4'b1001; #1;
        chkv("R12 all masked", int'(irq), 0);
        fw_irq_mask = 4'b0001; #1;
        chkv("R12 one unmasked", int'(irq), 1);
        fw_irq_mask = 4'b0000;
        fw_irq_clr = 4'b1111; step();
        chkv("R11 clear", int'(irq_pend), 0);
        fw_eop = 1; step();
        chkv("R7 to STATUS_OUT", int'(stage), 5);

        // setup during status stage, standard, no data
        do_setup(8'h00, 0);
        chkv("R9 stage_err", int'(stage_err), 1);
        chkv("R2 stage", int'(stage), 1);
        chkv("R3 standard", int'(req_fw), 0);
        fw_setup_ack = 1; step();
        chkv("R4 to STATUS_IN", int'(stage), 4);
        chkv("R9 err cleared by ack", int'(stage_err), 0);
        pk_status_zlp = 1; fw_irq_clr = 4'b0100; step();
        chkv("R8 idle", int'(stage), 0);
        chkv("R11 set wins", int'(irq_pend), 4'b0101);
        fw_eop = 1; step();
        chkv("R7 eop ignored", int'(stage), 0);
        fw_irq_clr = 4'b1111; step();

        // control write, class type, 8 bytes, packet length over cap
        do_setup(8'h21, 8);
        chkv("R3 class", int'(req_fw), 1);
        fw_setup_ack = 1; step();
        chkv("R4 to DATA_OUT", int'(stage), 3);
        pk_out_data = 1; pk_len = 4'd9; step();
        chkv("R6 ep0 flag", int'(irq_pend), 4'b0011);
        pk_status_nak = 1; step();
        chkv("R10 no flag when all sent", int'(irq_pend), 4'b0011);
        fw_eop = 1; step();
        chkv("R7 to STATUS_IN", int'(stage), 4);

        // weighted random phase
        for (int i = 0; i < 5000; i++) begin
            pk_setup      = ($urandom % 100) < 6;
            su_bmreq      = 8'($urandom);
            su_wlen       = (($urandom % 4) == 0) ? '0 : WLEN_W'($urandom % 40);
            pk_in_ack     = ($urandom % 100) < 30;
            pk_out_data   = ($urandom % 100) < 25;
            pk_len        = LEN_W'($urandom % 10);
            pk_status_zlp = ($urandom % 100) < 20;
            pk_status_nak = ($urandom % 100) < 10;
            fw_setup_ack  = ($urandom % 100) < 30;
            fw_buf_loaded = ($urandom % 100) < 30;
            fw_eop        = ($urandom % 100) < 8;
            fw_irq_clr    = 4'($urandom & $urandom & $urandom);
            if ((i % 50) == 0) fw_irq_mask = 4'($urandom);
            step();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule